// File: doc/BRIEF.md
# GPIO controller with interrupts

This block is a parameterised general-purpose pin controller with a small word-addressed register bus. Each pin has a stored output value, a direction bit, an input inversion bit and a blink enable. When a pin is an output, the block drives either its stored value or a shared square wave. Pin inputs pass through a two-stage synchroniser and are then inverted per pin when the inversion bit is set. The corrected levels can be read back. They also drive level interrupts and set sticky edge flags.

Each pin raises a request when its corrected level is high and its level mask bit is set, or when its sticky edge flag is set and its edge mask bit is set. The per-pin requests are ORed into one interrupt line per group of eight pins. Software can detect both edges of a pin by flipping that pin's inversion bit after each event. The block itself does no special handling for that case.

Reads are combinational. `bus_rdata` shows the addressed register while `bus_sel` is high and `bus_wr` is low, and is zero at other times. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset (active low), every direction bit is 1, so `pin_oe` is all zeros. The output, inversion, blink, level mask, edge mask and edge flag registers all read 0, and every `irq_grp` line is 0.
- R2: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). While the pin's blink enable is 0, `pin_out` carries the stored output bit.
- R3: The register word index is `bus_addr[4:2]`: 0 direction, 1 output, 2 inversion, 3 blink enable, 4 level mask, 5 edge mask, 6 edge flags, 7 corrected input. Indexes 0 to 5 read back the last value written.
- R4: The corrected input register reads the pin level XOR the inversion bit. A pin change driven before a clock edge is not yet visible after that edge, and is visible after the next edge.
- R5: A write to index 7 (corrected input) changes no register and no output.
- R6: A pin's edge flag is set when its corrected level goes from 0 to 1. With inversion 0 this is a rising pin edge, and with inversion 1 a falling pin edge. The flag stays set until software clears it.
- R7: A write to index 6 clears every edge flag whose write-data bit is 0 and leaves the flags whose bit is 1 unchanged.
- R8: A new edge on a pin in the same cycle as a clearing write to that pin's flag leaves the flag set.
- R9: The request of pin i is (corrected input i AND level mask i) OR (edge flag i AND edge mask i). `irq_grp[g]` is the OR of the requests of pins 8g to 8g+7.
- R10: A pin whose blink enable is 1 drives a shared square wave on `pin_out` instead of its stored bit. The wave toggles every `BLINK_HALF` clock cycles, and all blinking pins show the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_oe | output | NPINS | Per-pin driver enable |
| pin_out | output | NPINS | Per-pin drive value |
| irq_grp | output | NPINS/8 | One interrupt line per group of eight pins |

## Verification
The hardest case to reach is an edge that lands on the same clock edge as a write that clears that pin's flag. The pin change must be placed exactly two cycles before the write edge so that the synchroniser output rises in that cycle. The bench sequences the pin drive and the bus write on falling edges to hit that one cycle. In the same write it also clears a second, older flag, which shows that clearing still works for other pins. An inversion flip that makes the corrected level rise is another path that is easy to miss. The random phase changes inversion bits and pin levels in separate, settled steps, so each step of the reference model sees exactly one transition.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and register index type for the pin controller.
// Assumes word-aligned accesses; the byte-lane bits of the address are ignored.
package gpio_irq_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        RI_DIR    = 3'd0,
        RI_OUT    = 3'd1,
        RI_INV    = 3'd2,
        RI_BLINK  = 3'd3,
        RI_LVLMSK = 3'd4,
        RI_EDGMSK = 3'd5,
        RI_FLAGS  = 3'd6,
        RI_DATAIN = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Input path: two-flop synchroniser, per-pin inversion, and rising-edge
// detection on the corrected level. Assumes pin_in is asynchronous to clk.
module gpio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] inv,
    output logic [NPINS-1:0] corr,
    output logic [NPINS-1:0] rise
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    // Two-stage synchroniser on the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    // Corrected level as software and interrupt logic see it.
    always_comb corr = sync_q ^ inv;

    // Remember last corrected level to find 0-to-1 transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= corr;
    end

    // Active edge of the corrected level.
    always_comb rise = corr & ~prev_q;

endmodule

// File: rtl/gpio_blink_gen.sv
// Blink source: free-running prescaler that produces one 50 % duty square
// wave shared by all blinking pins. Assumes HALF >= 2.
module gpio_blink_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wave_q;

    // Count HALF cycles, then toggle the wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign wave = wave_q;

    // R10: the wave holds between prescaler wraps.
    a_r10_wave_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> $stable(wave_q));

    // R10: the wave flips on each wrap.
    a_r10_wave_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (wave_q != $past(wave_q)));

endmodule

// File: rtl/gpio_irq_agg.sv
// Interrupt aggregation: forms per-pin requests from level and edge sources
// and ORs them into one line per group. Assumes NPINS is a multiple of GRP.
module gpio_irq_agg #(
    parameter int NPINS = 32,
    parameter int GRP   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     corr,
    input  logic [NPINS-1:0]     lvl_msk,
    input  logic [NPINS-1:0]     flags,
    input  logic [NPINS-1:0]     edg_msk,
    output logic [NPINS/GRP-1:0] irq_grp
);

    localparam int NGRP = NPINS / GRP;

    logic [NPINS-1:0] pin_req;

    // Per-pin request: level source or latched edge source.
    always_comb pin_req = (corr & lvl_msk) | (flags & edg_msk);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // One summary line per group of GRP pins.
        assign irq_grp[g] = |pin_req[g*GRP +: GRP];
    end

    // R9: with both masks clear no line may be raised.
    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_msk == '0) && (edg_msk == '0)) |-> (irq_grp == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin controller: register file and bus decode, output drive
// with blink override, plus the input and interrupt sub-blocks.
// Assumes single-cycle word accesses and synchronous active-low reset.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int GRP        = 8,
    parameter int BLINK_HALF = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NPINS-1:0]     bus_wdata,
    output logic [NPINS-1:0]     bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS/GRP-1:0] irq_grp
);

    logic [NPINS-1:0] dir_q, out_q, inv_q, blk_q, lmsk_q, emsk_q, flags_q;
    logic [NPINS-1:0] corr, rise, keep_mask;
    logic             wave;
    reg_idx_e         widx;
    logic             wr_en, rd_en;

    always_comb begin
        widx  = reg_idx_e'(bus_addr[ADDR_W-1:2]);
        wr_en = bus_sel && bus_wr;
        rd_en = bus_sel && !bus_wr;
    end

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv(inv_q),
        .corr(corr), .rise(rise)
    );

    gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .wave(wave)
    );

    gpio_irq_agg #(.NPINS(NPINS), .GRP(GRP)) u_agg (
        .clk(clk), .rst_n(rst_n), .corr(corr), .lvl_msk(lmsk_q),
        .flags(flags_q), .edg_msk(emsk_q), .irq_grp(irq_grp)
    );

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            inv_q  <= '0;
            blk_q  <= '0;
            lmsk_q <= '0;
            emsk_q <= '0;
        end else if (wr_en) begin
            case (widx)
                RI_DIR:    dir_q  <= bus_wdata;
                RI_OUT:    out_q  <= bus_wdata;
                RI_INV:    inv_q  <= bus_wdata;
                RI_BLINK:  blk_q  <= bus_wdata;
                RI_LVLMSK: lmsk_q <= bus_wdata;
                RI_EDGMSK: emsk_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Bits written as 0 to the flag register are cleared; others kept.
    always_comb keep_mask = (wr_en && widx == RI_FLAGS) ? bus_wdata : '1;

    // Sticky edge flags; a new edge outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & keep_mask) | rise;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (widx)
                RI_DIR:    bus_rdata = dir_q;
                RI_OUT:    bus_rdata = out_q;
                RI_INV:    bus_rdata = inv_q;
                RI_BLINK:  bus_rdata = blk_q;
                RI_LVLMSK: bus_rdata = lmsk_q;
                RI_EDGMSK: bus_rdata = emsk_q;
                RI_FLAGS:  bus_rdata = flags_q;
                default:   bus_rdata = corr;
            endcase
        end
    end

    // Pad controls: driver on for outputs, blink wave overrides stored bit.
    always_comb begin
        pin_oe  = ~dir_q;
        pin_out = (blk_q & {NPINS{wave}}) | (~blk_q & out_q);
    end

    // R1: reset leaves every pin an input and the state registers empty.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '1 && out_q == '0 && blk_q == '0 && flags_q == '0));

    // R5: a write to the corrected-input slot disturbs no register.
    a_r5_datain_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == RI_DATAIN) |=> ($stable(dir_q) && $stable(out_q) &&
        $stable(inv_q) && $stable(blk_q) && $stable(lmsk_q) && $stable(emsk_q)));

    // R6, R8: a detected edge always lands in the flags, even under a clear.
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(rise)) == $past(rise)));

    // R7: without a flag write no set flag may drop.
    a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && widx == RI_FLAGS) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
// Self-checking bench: directed corner cases plus a seeded random phase
// compared against a bench-side reference model.
module gpio_irq_ctrl_tb_top;

    localparam int N    = 32;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata, pin_in = '0, pin_oe, pin_out;
    logic [3:0]   irq_grp;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [N-1:0] m_corr = '0, m_flags = '0, m_inv = '0, m_lm = '0, m_em = '0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N), .GRP(8), .BLINK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_grp(irq_grp)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(idx << 2); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(idx << 2);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [3:0] exp_irq(input logic [N-1:0] c, input logic [N-1:0] f);
        logic [N-1:0] req;
        logic [3:0]   r;
        req = (c & m_lm) | (f & m_em);
        for (int g = 0; g < 4; g++) r[g] = |req[g*8 +: 8];
        return r;
    endfunction

    // Update model after pins or inversion settled.
    task automatic model_step();
        logic [N-1:0] nc;
        nc = pin_in ^ m_inv;
        m_flags = m_flags | (nc & ~m_corr);
        m_corr = nc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d, v[6];
        int toggles;
        logic last;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, d); chk("R1 dir", d, '1);
        for (int i = 1; i < 7; i++) begin rd(i, d); chk("R1 reg", d, '0); end
        chk("R1 oe", pin_oe, '0);
        chk("R1 irq", {28'd0, irq_grp}, '0);

        // R3 readback of stored registers
        for (int i = 0; i < 6; i++) begin v[i] = $urandom(); wr(i, v[i]); end
        for (int i = 0; i < 6; i++) begin rd(i, d); chk("R3 readback", d, v[i]); end

        // R2 direction and static output
        wr(3, '0); wr(2, '0); wr(4, '0); wr(5, '0);
        wr(0, 32'hFFFF_0000); wr(1, 32'hA5C3_5A3C);
        @(negedge clk);
        chk("R2 oe", pin_oe, 32'h0000_FFFF);
        chk("R2 out", pin_out, 32'hA5C3_5A3C);
        wr(6, '0); settle();
        m_flags = '0; m_corr = '0; m_inv = '0; m_lm = '0; m_em = '0;

        // R4 two-edge latency through the synchroniser
        @(negedge clk); pin_in = 32'h0000_0011;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd28;
        @(negedge clk); #1 chk("R4 one edge", bus_rdata, '0);
        @(negedge clk); #1 chk("R4 two edges", bus_rdata, 32'h0000_0011);
        bus_sel = 1'b0;
        settle(); model_step();
        wr(2, 32'h0000_0100); m_inv = 32'h0000_0100; settle(); model_step();
        rd(7, d); chk("R4 inverted", d, 32'h0000_0111);

        // R5 write to corrected input ignored
        wr(7, '1);
        rd(7, d); chk("R5 datain", d, 32'h0000_0111);
        rd(0, d); chk("R5 dir", d, 32'hFFFF_0000);
        rd(2, d); chk("R5 inv", d, 32'h0000_0100);
        chk("R5 out", pin_out, 32'hA5C3_5A3C);

        // R6 rising with inversion 0, falling with inversion 1
        wr(6, '0); m_flags = '0;
        @(negedge clk); pin_in = 32'h0000_0031; settle(); model_step();
        rd(6, d); chk("R6 rise", d, 32'h0000_0020);
        @(negedge clk); pin_in = 32'h0000_0011; settle(); model_step();
        rd(6, d); chk("R6 fall no flag", d, 32'h0000_0020);
        @(negedge clk); pin_in = 32'h0000_0111; settle(); model_step();
        @(negedge clk); pin_in = 32'h0000_0011; settle(); model_step();
        rd(6, d); chk("R6 inverted fall", d, 32'h0000_0120);

        // R7 selective clear
        wr(6, 32'h0000_0100); m_flags = m_flags & 32'h0000_0100;
        rd(6, d); chk("R7 clear", d, 32'h0000_0100);

        // R8 edge coincides with a clearing write
        @(negedge clk); pin_in = 32'h0000_0811;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd24; bus_wdata = '0;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        settle(); m_flags = '0; model_step(); m_flags = 32'h0000_0800;
        rd(6, d); chk("R8 edge wins", d, 32'h0000_0800);

        // R9 level and edge requests into groups
        wr(4, 32'h0000_0010); m_lm = 32'h0000_0010;
        @(negedge clk); chk("R9 level grp0", {28'd0, irq_grp}, 32'h1);
        wr(5, 32'h0000_0800); m_em = 32'h0000_0800;
        @(negedge clk); chk("R9 edge grp1", {28'd0, irq_grp}, 32'h3);
        wr(4, '0); wr(5, '0); m_lm = '0; m_em = '0;

        // R10 blink override and shared phase
        wr(0, 32'hFFFF_FFE7); wr(1, 32'h0000_0008); wr(3, 32'h0000_0018);
        @(negedge clk); last = pin_out[3]; toggles = 0;
        for (int i = 0; i < 4*HALF; i++) begin
            @(negedge clk);
            if (pin_out[3] != last) toggles++;
            last = pin_out[3];
            if (pin_out[3] != pin_out[4]) chk("R10 phase", {31'd0, pin_out[4]}, {31'd0, pin_out[3]});
        end
        chk("R10 toggles", N'(toggles), N'(4));
        wr(3, '0); @(negedge clk);
        chk("R10 off", pin_out & 32'h18, 32'h08);

        // Random phase against the model
        for (int it = 0; it < 40; it++) begin
            logic [N-1:0] r;
            r = $urandom(); wr(2, r); m_inv = r; settle(); model_step();
            @(negedge clk); pin_in = $urandom(); settle(); model_step();
            r = $urandom(); wr(6, r); m_flags = m_flags & r;
            r = $urandom() & $urandom(); wr(4, r); m_lm = r;
            r = $urandom() & $urandom(); wr(5, r); m_em = r;
            rd(7, d); chk("R4 random datain", d, m_corr);
            rd(6, d); chk("R6 R7 random flags", d, m_flags);
            @(negedge clk); chk("R9 random irq", {28'd0, irq_grp}, {28'd0, exp_irq(m_corr, m_flags)});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule